// File: doc/BRIEF.md
# Swept Oscillator with Trapezoid Wave Shaper

This block is a sampled-data tone source whose pitch glides. A slow sweep register counts down by a fixed step on every sample strobe and reloads a programmable top value when it would pass below zero. The result is a sawtooth. A shifted copy of that sweep value, plus a fixed floor, forms the per-sample step of a second, faster sawtooth: the oscillator phase. The sweep slope therefore sets how quickly the tone moves, the top value and shift set the span, and the floor sets the lowest pitch.

The oscillator phase runs in one of two ways. In reload mode it restarts at a programmable level when a step would take it below zero. In free-wrap mode it is a plain modular down-counter that rolls over past zero. A purely combinational shaper turns the phase into a trapezoid that approximates a sine. It centres the phase about zero, doubles it and takes the magnitude to form a triangle. It then re-centres the triangle, triples it and clips it at symmetric limits of plus and minus 2^W, which is two-thirds of the tripled peak. This cancels the even harmonics and the third, so the lowest distortion product is the fifth. All arithmetic is shifts and adds.

The sweep control is a two-state machine. SW_IDLE is the state after reset, and the first strobe takes the transition "arm" into SW_RUN, loading the top value. In SW_RUN each strobe takes either "step", which decrements the sweep, or "reload", which restores the top value because the sweep is below the step. Both "arm" and "reload" raise the sweep-start pulse.

Top module: `sweep_trap_gen`

## Requirements
- R1: After reset the sweep value is 0, the start pulse is low and the phase is 0, so the shaped output equals the shaper result for phase 0.
- R2: The first strobe after reset loads the sweep with sweep_top and raises sweep_begin.
- R3: On each later strobe, if sweep < sweep_step the sweep reloads sweep_top. Otherwise it becomes sweep - sweep_step, so the sweep repeats every floor(top/step)+1 strobes.
- R4: sweep_begin is high for exactly the one clock after a strobe that loads the sweep, and low otherwise.
- R5: The oscillator step on a strobe is ((sweep before the strobe) >> sweep_shift) + freq_floor, truncated to W bits.
- R6: With free_wrap = 0, if phase < step the phase becomes reset_level, otherwise phase - step. A constant step therefore repeats with period floor(reset_level/step)+1.
- R7: With free_wrap = 1, the phase becomes (phase - step) mod 2^W.
- R8: wave_out = clamp(3*(|2*(phase - 2^(W-1))| - 2^(W-1)), -2^W, +2^W), signed, W+2 bits.
- R9: wave_out never leaves [-2^W, +2^W]. A full phase walk reaches both limits.
- R10: Without a strobe, the sweep value, the phase and wave_out hold, and sweep_begin is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strobe | input | 1 | One-cycle sample strobe |
| sweep_step | input | SW | Sweep decrement per sample |
| sweep_top | input | SW | Sweep reload value |
| sweep_shift | input | SHW | Right shift applied to the sweep before the floor is added |
| freq_floor | input | W | Minimum oscillator step |
| reset_level | input | W | Phase restart level in reload mode |
| free_wrap | input | 1 | 1: modular phase wrap; 0: reload mode |
| sweep_val | output | SW | Current sweep value |
| sweep_begin | output | 1 | Pulse after each sweep load |
| wave_out | output | W+2 | Shaped oscillator sample, two's complement |

## Verification
The assertions assume that strobe is never held high for two consecutive clocks. They also assume that the configuration inputs change only while no strobe is pending, so that a loaded sweep or phase can be compared with the value present one cycle earlier. The bench keeps within these assumptions by spacing every strobe with a low cycle and by changing parameters only during reset or idle gaps. Expected values come from an arithmetic model of the sweep, the phase and the shaper. The bench checks repetition periods by comparing recorded outputs one predicted period apart.

// File: rtl/stg_pkg.sv
package stg_pkg;
    typedef enum logic [0:0] {
        SW_IDLE = 1'b0,
        SW_RUN  = 1'b1
    } sweep_state_t;
endpackage

// File: rtl/stg_sweep.sv
module stg_sweep
    import stg_pkg::*;
#(
    parameter int SW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          strobe,
    input  logic [SW-1:0] step,
    input  logic [SW-1:0] top,
    output logic [SW-1:0] sweep,
    output logic          begin_pulse
);
    sweep_state_t state, state_nx;
    logic         load;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= SW_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        load     = 1'b0;
        unique case (state)
            SW_IDLE: if (strobe) begin state_nx = SW_RUN; load = 1'b1; end
            SW_RUN:  if (strobe && (sweep < step)) load = 1'b1;
            default: state_nx = SW_IDLE;
        endcase
    end

    // output process: sweep value and start pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sweep       <= '0;
            begin_pulse <= 1'b0;
        end else begin
            begin_pulse <= load;
            if (load)        sweep <= top;
            else if (strobe) sweep <= sweep - step;
        end
    end

    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe |=> $stable(sweep));
    assert_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        begin_pulse |-> $past(strobe));
    assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && state == SW_RUN && sweep >= step) |=> (sweep == $past(sweep) - $past(step)));
    assert_arm_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && state == SW_IDLE) |=> (begin_pulse && sweep == $past(top)));
endmodule

// File: rtl/stg_phase.sv
module stg_phase #(
    parameter int SW  = 12,
    parameter int W   = 12,
    parameter int SHW = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           strobe,
    input  logic [SW-1:0]  sweep,
    input  logic [SHW-1:0] shift,
    input  logic [W-1:0]   floor_in,
    input  logic [W-1:0]   level,
    input  logic           free_wrap,
    output logic [W-1:0]   phase
);
    logic [SW-1:0] scaled;
    logic [W-1:0]  inc;

    assign scaled = sweep >> shift;
    assign inc    = W'(scaled) + floor_in;

    always_ff @(posedge clk) begin
        if (!rst_n)                      phase <= '0;
        else if (strobe) begin
            if (free_wrap)               phase <= phase - inc;
            else if (phase < inc)        phase <= level;
            else                         phase <= phase - inc;
        end
    end

    assert_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && !free_wrap && phase < inc) |=> (phase == $past(level)));
    assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe |=> $stable(phase));
endmodule

// File: rtl/stg_shaper.sv
module stg_shaper #(
    parameter int W = 12
) (
    input  logic [W-1:0]        phase,
    output logic signed [W+1:0] wave
);
    localparam int XW = W + 3;
    localparam logic signed [XW-1:0] HALF = XW'(1) <<< (W - 1);
    localparam logic signed [XW-1:0] LIM  = XW'(1) <<< W;

    logic signed [XW-1:0] centred, dbl, tri_w, tri_c, tripled;

    always_comb begin
        centred = $signed({3'b000, phase}) - HALF;
        dbl     = centred <<< 1;
        tri_w   = (dbl < 0) ? -dbl : dbl;
        tri_c   = tri_w - HALF;
        tripled = tri_c + (tri_c <<< 1);
        if (tripled > LIM)       wave = (W+2)'(LIM);
        else if (tripled < -LIM) wave = (W+2)'(-LIM);
        else                     wave = (W+2)'(tripled);
    end
endmodule

// File: rtl/sweep_trap_gen.sv
module sweep_trap_gen #(
    parameter int SW  = 12,
    parameter int W   = 12,
    parameter int SHW = $clog2(SW) + 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           strobe,
    input  logic [SW-1:0]  sweep_step,
    input  logic [SW-1:0]  sweep_top,
    input  logic [SHW-1:0] sweep_shift,
    input  logic [W-1:0]   freq_floor,
    input  logic [W-1:0]   reset_level,
    input  logic           free_wrap,
    output logic [SW-1:0]  sweep_val,
    output logic           sweep_begin,
    output logic [W+1:0]   wave_out
);
    localparam logic signed [W+1:0] CLIP = (W+2)'(1) <<< W;

    logic [W-1:0]        phase;
    logic signed [W+1:0] wave_s;

    stg_sweep #(.SW(SW)) u_sweep (
        .clk(clk), .rst_n(rst_n), .strobe(strobe),
        .step(sweep_step), .top(sweep_top),
        .sweep(sweep_val), .begin_pulse(sweep_begin)
    );

    stg_phase #(.SW(SW), .W(W), .SHW(SHW)) u_phase (
        .clk(clk), .rst_n(rst_n), .strobe(strobe),
        .sweep(sweep_val), .shift(sweep_shift), .floor_in(freq_floor),
        .level(reset_level), .free_wrap(free_wrap), .phase(phase)
    );

    stg_shaper #(.W(W)) u_shape (.phase(phase), .wave(wave_s));

    assign wave_out = wave_s;

    assert_clip_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wave_s <= CLIP) && (wave_s >= -CLIP));
    assert_wave_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe |=> $stable(wave_out));
endmodule

// File: tb/sweep_trap_gen_test.sv
module sweep_trap_gen_test;
    localparam int SW = 6, W = 6, SHW = 3;
    localparam int M = 1 << W, H = 1 << (W - 1);

    logic clk = 0, rst_n = 0, strobe = 0, free_wrap = 0;
    logic [SW-1:0] sweep_step = 1, sweep_top = 0;
    logic [SHW-1:0] sweep_shift = 0;
    logic [W-1:0] freq_floor = 0, reset_level = 0;
    logic [SW-1:0] sweep_val;
    logic sweep_begin;
    logic [W+1:0] wave_out;

    int n_chk = 0, n_bad = 0;
    int ms, mp, mrun, mb;
    int rec [0:255];
    int nrec;
    bit done = 0;

    always #4 clk = ~clk;

    sweep_trap_gen #(.SW(SW), .W(W), .SHW(SHW)) uut (.*);

    function automatic int shape(int p);
        int c, t, v;
        c = p - H;
        t = (2 * c < 0) ? -2 * c : 2 * c;
        v = 3 * (t - H);
        if (v > M) v = M;
        if (v < -M) v = -M;
        return v;
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 0; strobe = 0;
        @(negedge clk); @(negedge clk); rst_n = 1;
        ms = 0; mp = 0; mrun = 0; mb = 0; nrec = 0;
    endtask

    // one strobe, then compare all outputs with the model
    task automatic pulse();
        int inc;
        @(negedge clk); strobe = 1;
        inc = ((ms >> sweep_shift) + freq_floor) % M;
        if (free_wrap) mp = (mp - inc + M) % M;
        else if (mp < inc) mp = reset_level;
        else mp = mp - inc;
        if (!mrun) begin ms = sweep_top; mb = 1; mrun = 1; end
        else if (ms < sweep_step) begin ms = sweep_top; mb = 1; end
        else begin ms = ms - sweep_step; mb = 0; end
        @(negedge clk); strobe = 0;
        chk(sweep_val == ms, "R3 sweep", sweep_val, ms);
        chk(sweep_begin == mb, "R4 begin", sweep_begin, mb);
        chk($signed(wave_out) == shape(mp), "R8 wave (R5 R6 R7)", $signed(wave_out), shape(mp));
        chk($signed(wave_out) <= M && $signed(wave_out) >= -M, "R9 clip", $signed(wave_out), M);
        if (nrec < 256) begin rec[nrec] = $signed(wave_out); nrec++; end
        @(negedge clk);
        chk(sweep_begin == 0, "R4 pulse width", sweep_begin, 0);
    endtask

    initial begin
        #1500000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int mx, mn, per, last, sv, sw;
        do_reset();
        @(negedge clk);
        chk(sweep_val == 0, "R1 sweep", sweep_val, 0);
        chk(sweep_begin == 0, "R1 begin", sweep_begin, 0);
        chk($signed(wave_out) == shape(0), "R1 wave", $signed(wave_out), shape(0));

        // R2 R3 R5: sweep period over every step value
        sweep_top = 45; sweep_shift = 2; freq_floor = 3; reset_level = 60; free_wrap = 0;
        for (int st = 1; st < 16; st++) begin
            sweep_step = SW'(st);
            do_reset();
            pulse();
            chk(sweep_val == 45 && mb == 1, "R2 arm", sweep_val, 45);
            per = 45 / st + 1; last = 0;
            for (int k = 1; k <= 3 * per; k++) begin
                pulse();
                if (mb) begin
                    chk(k - last == per, "R3 period", k - last, per);
                    last = k;
                end
            end
        end

        // R6: reload mode, constant step 7, level 50 -> period 8
        sweep_top = 0; sweep_step = 1; sweep_shift = 7; freq_floor = 7; reset_level = 50;
        do_reset();
        for (int k = 0; k < 40; k++) pulse();
        for (int k = 1; k + 8 < 40; k++)
            chk(rec[k] == rec[k + 8], "R6 period", rec[k + 8], rec[k]);

        // R7 R9: free wrap, step 3 -> period 64, full walk
        free_wrap = 1; freq_floor = 3;
        do_reset();
        for (int k = 0; k < 140; k++) pulse();
        mx = -1000; mn = 1000;
        for (int k = 0; k < 140; k++) begin
            if (rec[k] > mx) mx = rec[k];
            if (rec[k] < mn) mn = rec[k];
        end
        for (int k = 1; k + 64 < 140; k++)
            chk(rec[k] == rec[k + 64], "R7 period", rec[k + 64], rec[k]);
        chk(mx == M, "R9 top", mx, M);
        chk(mn == -M, "R9 bottom", mn, -M);

        // swept run mixing modes
        free_wrap = 0; sweep_top = 40; sweep_step = 5; sweep_shift = 1; freq_floor = 2; reset_level = 63;
        do_reset();
        for (int k = 0; k < 60; k++) pulse();

        // R10: no strobe, nothing moves
        sv = sweep_val; sw = $signed(wave_out);
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            chk(sweep_val == sv, "R10 sweep", sweep_val, sv);
            chk($signed(wave_out) == sw, "R10 wave", $signed(wave_out), sw);
            chk(sweep_begin == 0, "R10 begin", sweep_begin, 0);
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule